// File: doc/BRIEF.md
# Tree-Addressed Microinstruction Sequencer

This block produces the address sequence for a microprogram whose memory is organised as a binary tree. It never stores a branch target. The current address sits in a shift register, and the root of the tree is the value 1. A branch moves to a child by shifting one chosen condition bit in from the least significant end. A backward jump moves toward the root by a counted series of right shifts. A zero displacement jumps straight back to the root.

An external microprogram memory reads the word at `addr_o` while `fetch_o` is high. In the following cycles it presents the word's sequence opcode and its selector/displacement field on `op_i` and `sd_i`. It keeps them there for as long as that instruction runs.

The function units receive a one-cycle `func_start_o` strobe and answer with `func_done_i`. A start pulse runs the sequencer freely. A step pulse runs it one instruction per further step pulse.

Top module: `treeseq_top`

## Requirements
- R1: After reset, `addr_o` is 0, and `fetch_o`, `func_start_o`, `busy_o` and `overflow_o` are all low.
- R2: While stopped, a `start_i` pulse loads the root address 1 and clears the overflow flag. In the next cycle `fetch_o` is high for exactly one cycle, with `addr_o` equal to 1.
- R3: In free-running mode, the instruction is decoded in the cycle after the fetch cycle. The opcode encoding is 00 stop, 01 pre-test descend, 10 post-test descend and 11 ascend. `func_start_o` pulses in the decode cycle for every opcode except stop.
- R4: Pre-test descend shifts the address left at the end of the decode cycle. The selected condition sampled in that cycle enters at bit 0. The next fetch follows the cycle in which `func_done_i` is seen high.
- R5: Post-test descend keeps the address unchanged until `func_done_i` is seen high. At that clock edge it shifts left, taking in the condition selected in that same cycle. The fetch follows in the next cycle.
- R6: A selector value s greater than 0 picks `cond_i[s-1]`. The selector value 0 picks a constant 1.
- R7: Ascend with a nonzero displacement d holds `busy_o` high and `fetch_o` low for exactly d cycles after the decode cycle. The address halves once in each of those cycles, with 0 entering at the top. The sequencer then waits for `func_done_i` and fetches.
- R8: Ascend with displacement 0 sets the address to the root value 1 at the end of the decode cycle, and leaves the overflow flag unchanged.
- R9: Stop sets the address to 0 and clears the overflow flag. The sequencer stays stopped until a start or step pulse arrives.
- R10: `overflow_o` goes high when a left shift pushes a 1 out of the most significant address bit. It stays high until a stop or a start/step reload.
- R11: While stopped, a `step_i` pulse reloads the root like a start pulse but selects step mode. After every fetch the sequencer waits, with no strobe and with the address held, until the next `step_i` pulse. It decodes in the cycle after that pulse.
- R12: `func_done_i` has no effect except while the sequencer waits for function completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start or restart pulse, free-running mode |
| step_i | input | 1 | Single-step pulse |
| op_i | input | 2 | Sequence opcode of the fetched word |
| sd_i | input | SEL_W (3) | Selector or displacement field of the fetched word |
| cond_i | input | 2^SEL_W-1 (7) | External condition signals, selector values 1 and up |
| func_done_i | input | 1 | Function micro-orders completed |
| addr_o | output | ADDR_W (8) | Current microinstruction address |
| fetch_o | output | 1 | Fetch strobe for `addr_o` |
| func_start_o | output | 1 | Start strobe for the function micro-orders |
| busy_o | output | 1 | Ascend shifts in progress |
| overflow_o | output | 1 | Address has left the tree |

## Verification
All control state of this block shows up at the ports. A bad step counter or bad state bit changes the length of a `busy_o` run, or moves `fetch_o` by at least one cycle, within one instruction. A bad address bit appears on `addr_o` at the next fetch. Once shifted toward the most significant end, it either raises `overflow_o` or persists until the next root reload. The bench therefore compares every output on every cycle against an independent behavioural model, so any divergence is reported in the cycle where it first becomes visible.

// File: rtl/treeseq_pkg.sv
package treeseq_pkg;

  // Sequence opcode carried by every microinstruction
  typedef enum logic [1:0] {
    SQ_HALT      = 2'b00,
    SQ_DOWN_PRE  = 2'b01,
    SQ_DOWN_POST = 2'b10,
    SQ_CLIMB     = 2'b11
  } sq_op_e;

  // Commands from the control FSM to the address register
  typedef enum logic [2:0] {
    PC_KEEP,
    PC_ROOT,
    PC_ZERO,
    PC_CHILD,
    PC_PARENT
  } pc_cmd_e;

  // Sequencer states
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_HOLD,
    ST_DECODE,
    ST_WAIT,
    ST_CLIMB
  } sq_state_e;

endpackage

// File: rtl/treeseq_cond_sel.sv
module treeseq_cond_sel #(
  parameter int SEL_W = 3,
  localparam int NCOND = (1 << SEL_W) - 1
) (
  input  logic [SEL_W-1:0] sel_i,
  input  logic [NCOND-1:0] cond_i,
  output logic             bit_o
);

  // Source vector: slot 0 is tied high so that selector 0 yields a 1
  logic [NCOND:0] src_w;

  assign src_w[0] = 1'b1;

  for (genvar g = 1; g <= NCOND; g++) begin : g_src
    assign src_w[g] = cond_i[g-1];
  end

  assign bit_o = src_w[sel_i];

endmodule

// File: rtl/treeseq_pcr.sv
module treeseq_pcr
  import treeseq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  pc_cmd_e           cmd_i,
  input  logic              in_bit_i,
  input  logic              ovf_clr_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              ovf_o
);

  localparam logic [ADDR_W-1:0] ROOT = {{(ADDR_W-1){1'b0}}, 1'b1};

  logic [ADDR_W-1:0] addr_q;
  logic              ovf_q;
  logic              escape_w;

  function automatic logic [ADDR_W-1:0] child_of(input logic [ADDR_W-1:0] a,
                                                 input logic b);
    return {a[ADDR_W-2:0], b};
  endfunction

  function automatic logic [ADDR_W-1:0] parent_of(input logic [ADDR_W-1:0] a);
    return {1'b0, a[ADDR_W-1:1]};
  endfunction

  // A descent from a node in the deepest row leaves the tree
  assign escape_w = (cmd_i == PC_CHILD) && addr_q[ADDR_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else begin
      unique case (cmd_i)
        PC_ROOT:   addr_q <= ROOT;
        PC_ZERO:   addr_q <= '0;
        PC_CHILD:  addr_q <= child_of(addr_q, in_bit_i);
        PC_PARENT: addr_q <= parent_of(addr_q);
        default:   addr_q <= addr_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q <= 1'b0;
    end else if (ovf_clr_i) begin
      ovf_q <= 1'b0;
    end else if (escape_w) begin
      ovf_q <= 1'b1;
    end
  end

  assign addr_o = addr_q;
  assign ovf_o  = ovf_q;

  // R10
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !ovf_clr_i) |=> ovf_q);

  // R4
  child_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i == PC_CHILD) |=> (addr_q[ADDR_W-1:1] == $past(addr_q[ADDR_W-2:0])));

  // R7
  parent_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i == PC_PARENT) |=> (addr_q == ($past(addr_q) >> 1)));

endmodule

// File: rtl/treeseq_ctrl.sv
module treeseq_ctrl
  import treeseq_pkg::*;
#(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             step_i,
  input  logic [1:0]       op_i,
  input  logic [SEL_W-1:0] sd_i,
  input  logic             func_done_i,
  output pc_cmd_e          cmd_o,
  output logic             ovf_clr_o,
  output logic             fetch_o,
  output logic             func_start_o,
  output logic             busy_o
);

  sq_state_e        state_q, state_d;
  sq_op_e           op_w;
  logic             step_mode_q;
  logic             post_q;
  logic [SEL_W-1:0] cnt_q;
  logic             launch_w;
  logic             climb_last_w;

  assign op_w         = sq_op_e'(op_i);
  assign launch_w     = (state_q == ST_IDLE) && (start_i || step_i);
  assign climb_last_w = (state_q == ST_CLIMB) && (cnt_q == SEL_W'(1));

  always_comb begin
    state_d      = state_q;
    cmd_o        = PC_KEEP;
    ovf_clr_o    = 1'b0;
    func_start_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (launch_w) begin
          cmd_o     = PC_ROOT;
          ovf_clr_o = 1'b1;
          state_d   = ST_FETCH;
        end
      end
      ST_FETCH: state_d = step_mode_q ? ST_HOLD : ST_DECODE;
      ST_HOLD: begin
        if (step_i) state_d = ST_DECODE;
      end
      ST_DECODE: begin
        unique case (op_w)
          SQ_HALT: begin
            cmd_o     = PC_ZERO;
            ovf_clr_o = 1'b1;
            state_d   = ST_IDLE;
          end
          SQ_DOWN_PRE: begin
            cmd_o        = PC_CHILD;
            func_start_o = 1'b1;
            state_d      = ST_WAIT;
          end
          SQ_DOWN_POST: begin
            func_start_o = 1'b1;
            state_d      = ST_WAIT;
          end
          default: begin
            func_start_o = 1'b1;
            if (sd_i == '0) begin
              cmd_o   = PC_ROOT;
              state_d = ST_WAIT;
            end else begin
              state_d = ST_CLIMB;
            end
          end
        endcase
      end
      ST_WAIT: begin
        if (func_done_i) begin
          if (post_q) cmd_o = PC_CHILD;
          state_d = ST_FETCH;
        end
      end
      ST_CLIMB: begin
        cmd_o = PC_PARENT;
        if (climb_last_w) state_d = ST_WAIT;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      step_mode_q <= 1'b0;
      post_q      <= 1'b0;
      cnt_q       <= '0;
    end else begin
      state_q <= state_d;
      if (launch_w) step_mode_q <= !start_i;
      if (state_q == ST_DECODE) begin
        post_q <= (op_w == SQ_DOWN_POST);
        cnt_q  <= sd_i;
      end else if (state_q == ST_CLIMB) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign fetch_o = (state_q == ST_FETCH);
  assign busy_o  = (state_q == ST_CLIMB);

  // R2
  fetch_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_o |=> !fetch_o);

  // R7
  climb_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !climb_last_w) |=> busy_o);

  // R11
  hold_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HOLD && !step_i) |=> (state_q == ST_HOLD && !fetch_o));

  // R3
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fetch_o, func_start_o, busy_o}));

endmodule

// File: rtl/treeseq_top.sv
module treeseq_top
  import treeseq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int SEL_W  = 3,
  localparam int NCOND = (1 << SEL_W) - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              step_i,
  input  logic [1:0]        op_i,
  input  logic [SEL_W-1:0]  sd_i,
  input  logic [NCOND-1:0]  cond_i,
  input  logic              func_done_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              fetch_o,
  output logic              func_start_o,
  output logic              busy_o,
  output logic              overflow_o
);

  localparam logic [ADDR_W-1:0] ROOT = {{(ADDR_W-1){1'b0}}, 1'b1};

  pc_cmd_e cmd_w;
  logic    ovf_clr_w;
  logic    sel_bit_w;

  treeseq_cond_sel #(.SEL_W(SEL_W)) u_sel (
    .sel_i (sd_i),
    .cond_i(cond_i),
    .bit_o (sel_bit_w)
  );

  treeseq_ctrl #(.SEL_W(SEL_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .step_i      (step_i),
    .op_i        (op_i),
    .sd_i        (sd_i),
    .func_done_i (func_done_i),
    .cmd_o       (cmd_w),
    .ovf_clr_o   (ovf_clr_w),
    .fetch_o     (fetch_o),
    .func_start_o(func_start_o),
    .busy_o      (busy_o)
  );

  treeseq_pcr #(.ADDR_W(ADDR_W)) u_pcr (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_i    (cmd_w),
    .in_bit_i (sel_bit_w),
    .ovf_clr_i(ovf_clr_w),
    .addr_o   (addr_o),
    .ovf_o    (overflow_o)
  );

  // R9
  halt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_w == PC_ZERO) |=> (addr_o == '0 && !overflow_o));

  // R8
  root_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_w == PC_ROOT) |=> (addr_o == ROOT));

  // R6
  sel_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sd_i == '0) |-> sel_bit_w);

endmodule

// File: tb/treeseq_top_test.sv
module treeseq_top_test;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int AW = 8;
  localparam int SW = 3;
  localparam int NC = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic step_i = 1'b0;
  logic func_done_i = 1'b0;
  logic [1:0] op_i = 2'b00;
  logic [SW-1:0] sd_i = '0;
  logic [NC-1:0] cond_i = '0;
  logic [AW-1:0] addr_o;
  logic fetch_o, func_start_o, busy_o, overflow_o;

  always #2 clk = ~clk;

  treeseq_top #(.ADDR_W(AW), .SEL_W(SW)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .step_i(step_i),
    .op_i(op_i), .sd_i(sd_i), .cond_i(cond_i), .func_done_i(func_done_i),
    .addr_o(addr_o), .fetch_o(fetch_o), .func_start_o(func_start_o),
    .busy_o(busy_o), .overflow_o(overflow_o)
  );

  int n_checks = 0;
  int n_fail = 0;
  string tag = "R1";
  int mode = 0;
  bit cond_rand = 1'b1;
  logic [NC-1:0] cond_fix = '0;
  bit noise = 1'b0;
  bit req_start = 1'b0;
  bit req_step = 1'b0;
  bit armed = 1'b0;
  int dcnt = 0;
  int lat = 1;
  bit finished = 1'b0;

  // Behavioural reference: 0 idle, 1 fetch, 2 hold, 3 decode, 4 wait, 5 climbing
  int m_st = 0;
  int m_addr = 0;
  bit m_ovf = 1'b0;
  bit m_step = 1'b0;
  bit m_post = 1'b0;
  int m_cnt = 0;

  function automatic int pick(input int s, input logic [NC-1:0] c);
    if (s == 0) return 1;
    return int'(c[s-1]);
  endfunction

  function automatic void push_bit(input int b);
    if (m_addr >= (1 << (AW-1))) m_ovf = 1'b1;
    m_addr = (m_addr * 2 + b) % (1 << AW);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_addr = 0; m_ovf = 1'b0; m_step = 1'b0; m_post = 1'b0; m_cnt = 0;
    end else begin
      case (m_st)
        0: if (start_i || step_i) begin
             m_addr = 1; m_ovf = 1'b0; m_step = !start_i; m_st = 1;
           end
        1: m_st = m_step ? 2 : 3;
        2: if (step_i) m_st = 3;
        3: begin
             case (op_i)
               2'd0: begin m_addr = 0; m_ovf = 1'b0; m_st = 0; end
               2'd1: begin push_bit(pick(int'(sd_i), cond_i)); m_post = 1'b0; m_st = 4; end
               2'd2: begin m_post = 1'b1; m_st = 4; end
               default: begin
                 m_post = 1'b0;
                 if (sd_i == 0) begin m_addr = 1; m_st = 4; end
                 else begin m_cnt = int'(sd_i); m_st = 5; end
               end
             endcase
           end
        4: if (func_done_i) begin
             if (m_post) push_bit(pick(int'(sd_i), cond_i));
             m_st = 1;
           end
        default: begin
          m_addr = m_addr / 2;
          m_cnt = m_cnt - 1;
          if (m_cnt == 0) m_st = 4;
        end
      endcase
    end
  end

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Microprogram contents per test mode, indexed by tree address
  function automatic void prog(input int md, input int a,
                               output logic [1:0] op, output logic [SW-1:0] sd);
    int h;
    op = 2'd0;
    sd = '0;
    case (md)
      0: begin
        h = (a * 37 + 11) ^ (a >> 2);
        if (h % 8 == 0) op = 2'd0;
        else op = 2'((h >> 1) % 3 + 1);
        sd = SW'((h >> 3) % 8);
      end
      1: begin op = 2'd1; sd = '0; end
      2: begin
        if (a == 1) begin op = 2'd1; sd = '0; end
        else if (a == 3) begin op = 2'd2; sd = SW'(1); end
        else if (a == 6 || a == 7) begin op = 2'd3; sd = SW'(2); end
      end
      3: op = 2'd0;
      4: begin
        if (a == 1) begin op = 2'd1; sd = '0; end
        else if (a == 3) begin op = 2'd3; sd = '0; end
      end
      default: begin
        if (a == 1) begin op = 2'd1; sd = SW'(2); end
      end
    endcase
  endfunction

  task automatic model_cmp();
    chk(addr_o == AW'(m_addr), "addr_o", longint'(addr_o), longint'(m_addr));
    chk(fetch_o == (m_st == 1), "fetch_o", longint'(fetch_o), longint'(m_st == 1));
    chk(func_start_o == (m_st == 3 && op_i != 2'd0), "func_start_o",
        longint'(func_start_o), longint'(m_st == 3 && op_i != 2'd0));
    chk(busy_o == (m_st == 5), "busy_o", longint'(busy_o), longint'(m_st == 5));
    chk(overflow_o == m_ovf, "overflow_o", longint'(overflow_o), longint'(m_ovf));
  endtask

  task automatic drive();
    logic [1:0] nop;
    logic [SW-1:0] nsd;
    if (fetch_o) armed = 1'b0;
    if (func_start_o) begin
      armed = 1'b1;
      dcnt = lat;
    end else if (armed && dcnt > 0) begin
      dcnt--;
    end
    func_done_i = armed && (dcnt == 0);
    if (noise && !armed && fetch_o) func_done_i = 1'b1;
    cond_i = cond_rand ? NC'($urandom) : cond_fix;
    start_i = req_start; req_start = 1'b0;
    step_i = req_step; req_step = 1'b0;
    prog(mode, int'(addr_o), nop, nsd);
    op_i = nop;
    sd_i = nsd;
  endtask

  task automatic cyc();
    @(negedge clk);
    model_cmp();
    drive();
  endtask

  task automatic go_idle();
    mode = 3;
    lat = 1;
    repeat (25) cyc();
  endtask

  initial begin
    #400000;
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired in phase %s actual 0 expected 1", tag);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    int max_run, runs, run, root_fetches, max_addr;
    bit saw;
    // R1: reset state
    repeat (3) @(negedge clk);
    tag = "R1";
    chk(addr_o == '0, "reset addr_o", longint'(addr_o), 0);
    chk(!fetch_o && !func_start_o && !busy_o, "reset strobes",
        longint'({fetch_o, func_start_o, busy_o}), 0);
    chk(!overflow_o, "reset overflow_o", longint'(overflow_o), 0);
    rst_n = 1'b1;
    mode = 3;
    repeat (4) cyc();

    // R2 start and R6 selector choice
    tag = "R2";
    mode = 5; cond_rand = 1'b0; cond_fix = 7'b0000010; lat = 1;
    req_start = 1'b1;
    cyc(); cyc();
    chk(fetch_o && addr_o == AW'(1), "root fetch after start",
        longint'({fetch_o, addr_o}), longint'({1'b1, 8'h01}));
    tag = "R6";
    saw = 1'b0;
    repeat (12) begin cyc(); if (fetch_o && addr_o == AW'(3)) saw = 1'b1; end
    chk(saw, "selector 2 with condition bit 1 high reaches 3", 0, 1);
    go_idle();
    tag = "R6";
    mode = 5; cond_fix = 7'b1111101;
    req_start = 1'b1;
    saw = 1'b0;
    repeat (14) begin cyc(); if (fetch_o && addr_o == AW'(2)) saw = 1'b1; end
    chk(saw, "selector 2 with condition bit 1 low reaches 2", 0, 1);
    go_idle();

    // R10 overflow by repeated descent, then R9 stop clears it
    tag = "R10";
    mode = 1; cond_rand = 1'b1; lat = 1;
    req_start = 1'b1;
    repeat (80) cyc();
    chk(overflow_o, "overflow after descent past deepest row", longint'(overflow_o), 1);
    chk(addr_o == 8'hFF, "address after constant-1 descents", longint'(addr_o), 8'hFF);
    tag = "R9";
    mode = 3;
    repeat (10) cyc();
    chk(addr_o == '0 && !overflow_o, "stop clears address and overflow",
        longint'({overflow_o, addr_o}), 0);
    repeat (5) cyc();
    chk(!fetch_o && addr_o == '0, "stays stopped", longint'({fetch_o, addr_o}), 0);

    // R7 counted ascent, R5 post-test descent
    tag = "R7 R5";
    mode = 2; lat = 2;
    req_start = 1'b1;
    max_run = 0; runs = 0; run = 0;
    repeat (150) begin
      cyc();
      if (busy_o) run++;
      else begin
        if (run > 0) runs++;
        if (run > max_run) max_run = run;
        run = 0;
      end
    end
    tag = "R7";
    chk(max_run == 2, "busy run length for displacement 2", max_run, 2);
    chk(runs >= 3, "number of ascents", runs, 3);
    go_idle();

    // R8 ascent with zero displacement returns to root
    tag = "R8";
    mode = 4; lat = 1;
    req_start = 1'b1;
    root_fetches = 0; max_addr = 0;
    repeat (60) begin
      cyc();
      if (fetch_o && addr_o == AW'(1)) root_fetches++;
      if (int'(addr_o) > max_addr) max_addr = int'(addr_o);
    end
    chk(root_fetches >= 3, "fetches at root", root_fetches, 3);
    chk(max_addr == 3, "highest address reached", max_addr, 3);
    go_idle();

    // R11 single-step
    tag = "R11";
    mode = 0; lat = 1;
    req_step = 1'b1;
    cyc(); cyc();
    chk(fetch_o && addr_o == AW'(1), "step loads root and fetches",
        longint'({fetch_o, addr_o}), longint'({1'b1, 8'h01}));
    for (int i = 0; i < 5; i++) begin
      cyc();
      chk(!fetch_o && !busy_o && addr_o == AW'(1), "held without step pulse",
          longint'({fetch_o, busy_o, addr_o}), 1);
    end
    for (int i = 0; i < 400; i++) begin
      if (i % 4 == 0) req_step = 1'b1;
      cyc();
    end
    go_idle();

    // R3 R4 R5 R12 mixed programs, random conditions, spurious completions
    tag = "R3 R4 R5 R12";
    noise = 1'b1; mode = 0;
    for (int i = 0; i < 3000; i++) begin
      lat = (i % 3) + 1;
      if (i % 25 == 0) req_start = 1'b1;
      cyc();
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule